// File: doc/BRIEF.md
# Signed Range-Check Sequencer

This block checks a signed 16-bit index against a pair of signed limits kept in memory. It is started with a one-cycle strobe. It then fetches two words in turn over a simple read port. The first word, at the operand address, is the lowest allowed value. The second word, one word higher, is the highest allowed value. If the index lies outside that closed range, the block raises an exception request with a fixed vector. It also hands back the instruction pointer that the exception entry logic must save.

The saved pointer is normally the start of the checking instruction. The `cur_ip` input is taken to point just past the opcode and addressing byte, so the block steps back two bytes, or three when a segment override prefix came before the instruction. When the `alt_variant` strap is high, the block reports the instruction after the check instead. In that case the saved pointer is `cur_ip + instr_len`, where `instr_len` counts the displacement bytes still to come. Decoding, exception entry and cycle accounting are handled elsewhere.

Top module: `bound_chk`

## Requirements
- R1: After an accepted start, the block first holds `mem_rd` high with `mem_addr` equal to the operand address until `mem_rvalid`. It then holds `mem_rd` high with `mem_addr` equal to the operand address plus 2 until `mem_rvalid`. No other reads are issued.
- R2: The index, the lower limit (first word) and the upper limit (second word) are compared as two's-complement signed 16-bit values.
- R3: An index equal to the lower limit or to the upper limit is in range and raises no trap.
- R4: When index < lower or index > upper, `trap_req` is 1 and `trap_vec` is 5. When the index is in range, `trap_req` is 0 and `trap_vec` is 0.
- R5: On a trap with `alt_variant`=0 and `seg_pfx`=0, `saved_ip` equals `cur_ip - 2`, taken modulo 2^16.
- R6: On a trap with `alt_variant`=0 and `seg_pfx`=1, `saved_ip` equals `cur_ip - 3`, taken modulo 2^16.
- R7: On a trap with `alt_variant`=1, `saved_ip` equals `cur_ip + instr_len`, whatever the value of `seg_pfx`.
- R8: `done` is high for exactly one cycle per check, in the cycle after the second read data is accepted. `trap_req`, `trap_vec` and `saved_ip` are non-zero only in that cycle, and `saved_ip` is 0 when there is no trap.
- R9: A synchronous reset, including one in the middle of a check, returns the block to idle. In the cycle after reset, `mem_rd`, `done`, `trap_req`, `trap_vec` and `saved_ip` are all 0.
- R10: A start strobe while a check is in progress is ignored. It does not change the reads issued, the captured operands or the result, and it does not queue a second check.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a check; accepted only when idle |
| index_val | input | 16 | Signed index to test |
| opnd_addr | input | 20 | Byte address of the lower limit word |
| cur_ip | input | 16 | Instruction pointer just past opcode and addressing byte |
| instr_len | input | 2 | Remaining instruction bytes after `cur_ip` |
| seg_pfx | input | 1 | A segment override prefix was present |
| alt_variant | input | 1 | Strap: report the following instruction on a trap |
| mem_rd | output | 1 | Read request, held until `mem_rvalid` |
| mem_addr | output | 20 | Read byte address |
| mem_rdata | input | 16 | Read data, valid with `mem_rvalid` |
| mem_rvalid | input | 1 | Read data valid |
| done | output | 1 | One-cycle completion pulse |
| trap_req | output | 1 | Exception request, valid with `done` |
| trap_vec | output | 8 | Exception vector, 5 on a trap |
| saved_ip | output | 16 | Instruction pointer to save on a trap |

## Verification
On every cycle, the assertions check the shape of the handshake and of the result. A pending read keeps its request and address until data arrives. `done` never lasts two cycles and never overlaps a read. A trap only appears with `done` and always carries vector 5. `saved_ip` is zero without a trap, and all outputs are quiet after reset. The correctness of the verdict needs the bench's scenarios. These cover signed versus unsigned ordering, equality at each limit, the three saved-pointer rules including wrap-around, the address order of the two reads, a start ignored mid-check and a reset that aborts a check.

// File: rtl/bchk_pkg.sv
package bchk_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RD_LO = 2'd1,
      ST_RD_HI = 2'd2,
      ST_FIN   = 2'd3
   } bchk_state_e;
endpackage

// File: rtl/bchk_seq.sv
module bchk_seq
   import bchk_pkg::*;
#(
   parameter int ADDR_W    = 20,
   parameter int DATA_W    = 16,
   parameter int WORD_STEP = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [ADDR_W-1:0] opnd_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_rvalid,
   output logic              accept,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] lo_q,
   output logic [DATA_W-1:0] hi_q,
   output bchk_state_e       state
);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_STEP);

   logic [ADDR_W-1:0] addr_q;

   assign accept   = start && (state == ST_IDLE);
   assign mem_rd   = (state == ST_RD_LO) || (state == ST_RD_HI);
   assign mem_addr = (state == ST_RD_HI) ? addr_q + STEP : addr_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         state  <= ST_IDLE;
         addr_q <= '0;
         lo_q   <= '0;
         hi_q   <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (accept) begin
                  addr_q <= opnd_addr;
                  state  <= ST_RD_LO;
               end
            end
            ST_RD_LO: begin
               if (mem_rvalid) begin
                  lo_q  <= mem_rdata;
                  state <= ST_RD_HI;
               end
            end
            ST_RD_HI: begin
               if (mem_rvalid) begin
                  hi_q  <= mem_rdata;
                  state <= ST_FIN;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/bchk_cmp.sv
module bchk_cmp #(
   parameter int DATA_W    = 16,
   parameter int CMP_STYLE = 0
) (
   input  logic [DATA_W-1:0] idx,
   input  logic [DATA_W-1:0] lo,
   input  logic [DATA_W-1:0] hi,
   output logic              out_of_range
);
   localparam int EXT_W = DATA_W + 1;

   logic below, above;

   generate
      if (CMP_STYLE == 0) begin : g_relational
         assign below = $signed(idx) < $signed(lo);
         assign above = $signed(idx) > $signed(hi);
      end else begin : g_subtract
         logic [EXT_W-1:0] d_lo, d_hi;
         assign d_lo  = {idx[DATA_W-1], idx} - {lo[DATA_W-1], lo};
         assign d_hi  = {hi[DATA_W-1], hi} - {idx[DATA_W-1], idx};
         assign below = d_lo[EXT_W-1];
         assign above = d_hi[EXT_W-1];
      end
   endgenerate

   assign out_of_range = below | above;
endmodule

// File: rtl/bchk_ipfix.sv
module bchk_ipfix #(
   parameter int IP_W      = 16,
   parameter int LEN_W     = 2,
   parameter int BASE_BACK = 2
) (
   input  logic [IP_W-1:0]  cur_ip,
   input  logic [LEN_W-1:0] len,
   input  logic             seg,
   input  logic             alt,
   output logic [IP_W-1:0]  fixed_ip
);
   localparam logic [IP_W-1:0] BACK0 = IP_W'(BASE_BACK);

   logic [IP_W-1:0] back;

   assign back     = BACK0 + IP_W'(seg);
   assign fixed_ip = alt ? cur_ip + IP_W'(len) : cur_ip - back;
endmodule

// File: rtl/bound_chk.sv
module bound_chk
   import bchk_pkg::*;
#(
   parameter int ADDR_W    = 20,
   parameter int DATA_W    = 16,
   parameter int IP_W      = 16,
   parameter int LEN_W     = 2,
   parameter int VEC_W     = 8,
   parameter int TRAP_VEC  = 5,
   parameter int WORD_STEP = 2,
   parameter int BASE_BACK = 2,
   parameter int CMP_STYLE = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [DATA_W-1:0] index_val,
   input  logic [ADDR_W-1:0] opnd_addr,
   input  logic [IP_W-1:0]   cur_ip,
   input  logic [LEN_W-1:0]  instr_len,
   input  logic              seg_pfx,
   input  logic              alt_variant,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_rvalid,
   output logic              done,
   output logic              trap_req,
   output logic [VEC_W-1:0]  trap_vec,
   output logic [IP_W-1:0]   saved_ip
);
   localparam logic [VEC_W-1:0] VEC_CODE = VEC_W'(TRAP_VEC);

   generate
      if (TRAP_VEC < 0 || TRAP_VEC >= (1 << VEC_W)) begin : g_bad_vec
         $error("TRAP_VEC does not fit VEC_W");
      end
      if (WORD_STEP < 1 || DATA_W < 2 || IP_W < 4) begin : g_bad_geom
         $error("bad word step or width");
      end
      if (CMP_STYLE != 0 && CMP_STYLE != 1) begin : g_bad_style
         $error("CMP_STYLE must be 0 or 1");
      end
   endgenerate

   bchk_state_e       state;
   logic              accept, oor;
   logic [DATA_W-1:0] lo_q, hi_q, idx_q;
   logic [IP_W-1:0]   ip_q, fix_ip;
   logic [LEN_W-1:0]  len_q;
   logic              seg_q, alt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         idx_q <= '0;
         ip_q  <= '0;
         len_q <= '0;
         seg_q <= 1'b0;
         alt_q <= 1'b0;
      end else if (accept) begin
         idx_q <= index_val;
         ip_q  <= cur_ip;
         len_q <= instr_len;
         seg_q <= seg_pfx;
         alt_q <= alt_variant;
      end
   end

   bchk_seq #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORD_STEP(WORD_STEP)
   ) u_seq (
      .clk(clk), .rst(rst), .start(start), .opnd_addr(opnd_addr),
      .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid), .accept(accept),
      .mem_rd(mem_rd), .mem_addr(mem_addr), .lo_q(lo_q), .hi_q(hi_q),
      .state(state)
   );

   bchk_cmp #(
      .DATA_W(DATA_W), .CMP_STYLE(CMP_STYLE)
   ) u_cmp (
      .idx(idx_q), .lo(lo_q), .hi(hi_q), .out_of_range(oor)
   );

   bchk_ipfix #(
      .IP_W(IP_W), .LEN_W(LEN_W), .BASE_BACK(BASE_BACK)
   ) u_ipfix (
      .cur_ip(ip_q), .len(len_q), .seg(seg_q), .alt(alt_q),
      .fixed_ip(fix_ip)
   );

   assign done     = (state == ST_FIN);
   assign trap_req = done & oor;
   assign trap_vec = trap_req ? VEC_CODE : '0;
   assign saved_ip = trap_req ? fix_ip : '0;
endmodule

// File: rtl/bound_chk_chk.sv
module bound_chk_chk #(
   parameter int ADDR_W   = 20,
   parameter int IP_W     = 16,
   parameter int VEC_W    = 8,
   parameter int TRAP_VEC = 5
) (
   input logic              clk,
   input logic              rst,
   input logic              mem_rd,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_rvalid,
   input logic              done,
   input logic              trap_req,
   input logic [VEC_W-1:0]  trap_vec,
   input logic [IP_W-1:0]   saved_ip
);
   // R1: a pending read holds its request and address until data arrives
   assert_read_held_R1: assert property (@(posedge clk) disable iff (rst)
      (mem_rd && !mem_rvalid) |=> (mem_rd && $stable(mem_addr)));

   // R4: a trap always carries the fixed vector
   assert_trap_vector_R4: assert property (@(posedge clk) disable iff (rst)
      trap_req |-> (trap_vec == VEC_W'(TRAP_VEC)));

   // R8: done is a single-cycle pulse
   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   // R8: the trap only appears with done, never during a read
   assert_trap_with_done_R8: assert property (@(posedge clk) disable iff (rst)
      trap_req |-> (done && !mem_rd));

   // R8: no vector and no saved pointer without a trap
   assert_quiet_no_trap_R8: assert property (@(posedge clk) disable iff (rst)
      !trap_req |-> (trap_vec == '0 && saved_ip == '0));

   // R9: everything quiet in the cycle after reset
   assert_reset_idle_R9: assert property (@(posedge clk)
      $past(rst) |-> (!mem_rd && !done && !trap_req));
endmodule

bind bound_chk bound_chk_chk #(
   .ADDR_W(ADDR_W), .IP_W(IP_W), .VEC_W(VEC_W), .TRAP_VEC(TRAP_VEC)
) u_chk (
   .clk(clk), .rst(rst), .mem_rd(mem_rd), .mem_addr(mem_addr),
   .mem_rvalid(mem_rvalid), .done(done), .trap_req(trap_req),
   .trap_vec(trap_vec), .saved_ip(saved_ip)
);

// File: tb/bound_chk_tb.sv
`timescale 1ns/1ps
module bound_chk_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [15:0] index_val = '0;
   logic [19:0] opnd_addr = '0;
   logic [15:0] cur_ip = '0;
   logic [1:0]  instr_len = '0;
   logic        seg_pfx = 1'b0;
   logic        alt_variant = 1'b0;
   logic        mem_rd;
   logic [19:0] mem_addr;
   logic [15:0] mem_rdata = '0;
   logic        mem_rvalid = 1'b0;
   logic        done, trap_req;
   logic [7:0]  trap_vec;
   logic [15:0] saved_ip;

   int n_cmp = 0;
   int n_bad = 0;
   int cycles = 0;

   always #2.5 clk = ~clk;

   bound_chk u_dut (
      .clk(clk), .rst(rst), .start(start), .index_val(index_val),
      .opnd_addr(opnd_addr), .cur_ip(cur_ip), .instr_len(instr_len),
      .seg_pfx(seg_pfx), .alt_variant(alt_variant), .mem_rd(mem_rd),
      .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
      .done(done), .trap_req(trap_req), .trap_vec(trap_vec),
      .saved_ip(saved_ip)
   );

   // memory model
   logic [19:0] m_base = '0;
   logic [15:0] m_lo = '0, m_hi = '0;
   int          lat = 0;
   int          wcnt = 0;
   logic [19:0] alog [4];
   int          log_n = 0;

   always @(posedge clk) begin
      if (mem_rd && !mem_rvalid && !rst) begin
         if (wcnt >= lat) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= (mem_addr == m_base) ? m_lo :
                          (mem_addr == m_base + 20'd2) ? m_hi : 16'hDEAD;
            if (log_n < 4) alog[log_n] <= mem_addr;
            log_n <= log_n + 1;
            wcnt  <= 0;
         end else begin
            wcnt <= wcnt + 1;
         end
      end else begin
         mem_rvalid <= 1'b0;
      end
   end

   task automatic summary_and_end();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 100000) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
         summary_and_end();
      end
   end

   task automatic check(input string rq, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
      end
   endtask

   task automatic launch(input logic [15:0] idx, input logic [19:0] addr,
                         input logic [15:0] lo, input logic [15:0] hi,
                         input logic [15:0] ip, input logic [1:0] len,
                         input logic seg, input logic alt, input int l);
      @(negedge clk);
      index_val = idx; opnd_addr = addr; cur_ip = ip; instr_len = len;
      seg_pfx = seg; alt_variant = alt;
      m_base = addr; m_lo = lo; m_hi = hi; lat = l; wcnt = 0; log_n = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done(input string rq, output bit ok);
      ok = 1'b0;
      for (int k = 0; k < 200; k++) begin
         if (done) begin ok = 1'b1; break; end
         @(negedge clk);
      end
      if (!ok) check(rq, "done seen", 32'd0, 32'd1);
   endtask

   task automatic result(input string rq, input logic [19:0] addr,
                         input bit exp_trap, input logic [15:0] exp_ip);
      bit ok;
      wait_done(rq, ok);
      if (ok) begin
         check(rq, "trap_req", 32'(trap_req), 32'(exp_trap));
         check(rq, "trap_vec", 32'(trap_vec), exp_trap ? 32'd5 : 32'd0);
         check(rq, "saved_ip", 32'(saved_ip), exp_trap ? 32'(exp_ip) : 32'd0);
         check("R1", "read count", 32'(log_n), 32'd2);
         check("R1", "first read addr", 32'(alog[0]), 32'(addr));
         check("R1", "second read addr", 32'(alog[1]), 32'(addr + 20'd2));
         @(negedge clk);
         check("R8", "done one cycle", 32'(done), 32'd0);
      end
   endtask

   function automatic logic [15:0] exp_ip(input logic [15:0] ip,
                                          input logic [1:0] len,
                                          input logic seg, input logic alt);
      if (alt) return ip + 16'(len);
      return ip - (seg ? 16'd3 : 16'd2);
   endfunction

   localparam int NV = 10;
   localparam logic [15:0] V_IDX [NV] = '{16'h0005, 16'hFFFB, 16'h0010, 16'hFFF0, 16'h0007,
                                          16'h0014, 16'h8000, 16'h7FFF, 16'h0001, 16'h0030};
   localparam logic [15:0] V_LO  [NV] = '{16'h0000, 16'hFFF6, 16'hFFF0, 16'hFFF8, 16'h0007,
                                          16'h0007, 16'h8001, 16'h0000, 16'h0002, 16'h0000};
   localparam logic [15:0] V_HI  [NV] = '{16'h000A, 16'h0003, 16'h0008, 16'h0010, 16'h0014,
                                          16'h0014, 16'h7FFF, 16'h7FFE, 16'h8000, 16'h0020};
   localparam logic [15:0] V_IP  [NV] = '{16'h1000, 16'h2000, 16'h3002, 16'h4004, 16'h5000,
                                          16'h6000, 16'h7003, 16'h8000, 16'h0001, 16'hFFFF};
   localparam logic [1:0]  V_LEN [NV] = '{2'd0, 2'd1, 2'd2, 2'd0, 2'd1,
                                          2'd2, 2'd1, 2'd2, 2'd0, 2'd3};
   localparam logic        V_SEG [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1,
                                          1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
   localparam logic        V_ALT [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
                                          1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
   localparam logic        V_TRP [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0,
                                          1'b0, 1'b1, 1'b1, 1'b1, 1'b1};
   localparam string       V_RQ  [NV] = '{"R2", "R2", "R4_R5", "R4_R5", "R3",
                                          "R3", "R6", "R7", "R2_R5", "R7"};

   initial begin
      // R9: reset state
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check("R9", "mem_rd after reset", 32'(mem_rd), 32'd0);
      check("R9", "done after reset", 32'(done), 32'd0);
      check("R9", "trap_req after reset", 32'(trap_req), 32'd0);
      check("R9", "trap_vec after reset", 32'(trap_vec), 32'd0);
      check("R9", "saved_ip after reset", 32'(saved_ip), 32'd0);

      for (int i = 0; i < NV; i++) begin
         logic [19:0] a;
         a = 20'h00100 + 20'(i * 16);
         launch(V_IDX[i], a, V_LO[i], V_HI[i], V_IP[i], V_LEN[i],
                V_SEG[i], V_ALT[i], i % 3);
         result(V_RQ[i], a, V_TRP[i],
                exp_ip(V_IP[i], V_LEN[i], V_SEG[i], V_ALT[i]));
      end

      // R10: start during a check is ignored and not queued
      launch(16'h0004, 20'h0A000, 16'h0000, 16'h0008, 16'h1234, 2'd0, 1'b0, 1'b0, 3);
      @(negedge clk);
      index_val = 16'h7000; opnd_addr = 20'h0B000; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      result("R10", 20'h0A000, 1'b0, 16'h0000);
      begin
         int busy = 0;
         for (int k = 0; k < 6; k++) begin
            busy += int'(mem_rd) + int'(done);
            @(negedge clk);
         end
         check("R10", "no queued check", 32'(busy), 32'd0);
      end

      // R9: reset in the middle of a check
      launch(16'h0100, 20'h0C000, 16'h0000, 16'h0010, 16'h2222, 2'd0, 1'b0, 1'b0, 4);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      check("R9", "mem_rd after mid reset", 32'(mem_rd), 32'd0);
      check("R9", "done after mid reset", 32'(done), 32'd0);
      begin
         int act = 0;
         for (int k = 0; k < 8; k++) begin
            act += int'(mem_rd) + int'(done);
            @(negedge clk);
         end
         check("R9", "stays idle after mid reset", 32'(act), 32'd0);
      end
      launch(16'hFFFF, 20'h0D000, 16'h0000, 16'h0010, 16'h0002, 2'd0, 1'b0, 1'b0, 1);
      result("R9_R5", 20'h0D000, 1'b1, 16'h0000);

      summary_and_end();
   end
endmodule